// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is a half-duplex serial slave for a control port. The port has an active-low select, a serial clock and one shared data line. A host sends 24-bit frames, most significant bit first. Each frame holds a direction flag, a 15-bit register address and a data byte. Only one 8-bit control register exists. Its upper two bits choose a fast-attack attenuation step and its lower six bits carry a gain code. Downstream logic reads that byte directly from `ctrl_o`.

The three serial inputs are brought into the system clock domain through a synchronizer. Their edges are then detected by comparing against the previous sample. Write frames update the register once the last bit has arrived. Read frames return the register contents on the same data line. The block drives a separate output value and a tristate enable, which the pad ring combines into the bidirectional pin.

Top module: `spi3w_ctrl_slave`

## Requirements
- R1: After reset is asserted, `ctrl_o` is 0x00 (maximum gain, smallest attack step) and `spi_sdio_oe_o` is 0.
- R2: A frame carries bit 23 = direction (0 write, 1 read), bits 22..8 = address, bits 7..0 = data, and is sent bit 23 first. The slave samples each bit on a rising serial clock edge while select is low. A complete 24-bit write frame to address 0x100 loads its data byte into `ctrl_o`: bits 7:6 form the attack step and bits 5:0 form the gain code.
- R3: A complete write frame to any address other than 0x100 leaves `ctrl_o` unchanged.
- R4: A write frame that ends (select goes high) before its 24th bit leaves `ctrl_o` unchanged.
- R5: A read frame to address 0x100 returns `ctrl_o` on `spi_sdio_o`, bit 7 first. Each bit changes after a falling serial clock edge and is stable at the next rising edge.
- R6: A read frame to any address other than 0x100 returns 0x00.
- R7: `spi_sdio_oe_o` is 1 only during the eight data bit times of a read frame. That window starts after the falling edge that follows the 16th rising edge and ends after the falling edge that follows the 24th. The enable is 0 during the header, during the whole of any write frame, and whenever select is high.
- R8: Select high clears the bit counter, so a frame that follows an aborted one is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_ni | input | 1 | Active-low select framing one transaction |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_sdio_i | input | 1 | Data line value seen at the pad |
| spi_sdio_o | output | 1 | Readback data driven toward the pad |
| spi_sdio_oe_o | output | 1 | Pad output enable for the data line |
| ctrl_o | output | 8 | Control register: attack step [7:6], gain code [5:0] |

## Verification
The bench goes after frames that should leave the register alone. One case writes to an address that differs from 0x100 only in a low bit; a loose address decoder would accept it and corrupt the gain. Another case cuts a write off one bit short; a slave that commits on the 23rd bit, or that keeps its counter across frames, would load a shifted byte. A case then starts a clean frame after an abort; a slave that does not clear its counter on select high would misread that frame. Readback is checked bit by bit between edges. An off-by-one in the count would show up as a shifted byte or as an enable that switches one bit time early or late. Reads to 0x4100 and 0x000 check that the address is fully decoded when the slave picks its readback source.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  localparam int unsigned CMD_W = 1;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi3w_frame_rx.sv
module spi3w_frame_rx
  import spi3w_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sclk_fall_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_d;
  logic               sclk_rise;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rw_q;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_i;
  end

  assign sclk_rise   = sclk_i & ~sclk_d & ~cs_n_i;
  assign sclk_fall_o = ~sclk_i & sclk_d & ~cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
    end else if (cs_n_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
    end else if (sclk_rise && cnt_q != CNT_FULL) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdio_i};
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == '0) rw_q <= sdio_i;
    end
  end

  // frame as it stands once the final bit is on the line
  assign frame      = {shreg_q[FRAME_W-2:0], sdio_i};
  assign wr_en_o    = sclk_rise && (cnt_q == CNT_LAST) && (frame[FRAME_W-1] == CMD_WRITE);
  assign wr_addr_o  = frame[FRAME_W-2 -: ADDR_W];
  assign wr_data_o  = frame[DATA_W-1:0];
  assign hdr_addr_o = shreg_q[ADDR_W-1:0];
  assign cnt_o      = cnt_q;
  assign rw_o       = rw_q;
endmodule

// File: rtl/spi3w_ctrl_reg.sv
module spi3w_ctrl_reg #(
  parameter int unsigned     ADDR_W    = 15,
  parameter int unsigned     DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == CTRL_ADDR)   ctrl_q <= wr_data_i;
  end

  assign rd_data_o = (rd_addr_i == CTRL_ADDR) ? ctrl_q : '0;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/spi3w_readback_tx.sv
module spi3w_readback_tx
  import spi3w_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned HDR_W   = 16,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdio_o,
  output logic              oe_o
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [DATA_W-1:0] sh_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (cs_n_i) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (sclk_fall_i) begin
      if (cnt_i == CNT_HDR && rw_i == CMD_READ) begin
        sh_q <= rd_data_i;
        oe_q <= 1'b1;
      end else if (cnt_i == CNT_FULL) begin
        sh_q <= '0;
        oe_q <= 1'b0;
      end else if (oe_q) begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdio_o = oe_q & sh_q[DATA_W-1];
  assign oe_o   = oe_q;
endmodule

// File: rtl/spi3w_ctrl_slave.sv
module spi3w_ctrl_slave #(
  parameter int unsigned       ADDR_W      = 15,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 15'h100,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_cs_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int unsigned HDR_W   = spi3w_pkg::CMD_W + ADDR_W;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, sdio_s;
  logic              sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rw_q;
  logic [ADDR_W-1:0] hdr_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  // select idles high, so it resets high
  spi3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_sdio_i, spi_sclk_i, spi_cs_ni}),
    .q_o    (pins_s)
  );
  assign {sdio_s, sclk_s, cs_s} = pins_s;

  spi3w_frame_rx #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_s),
    .sclk_i      (sclk_s),
    .sdio_i      (sdio_s),
    .sclk_fall_o (sclk_fall),
    .cnt_o       (bit_cnt),
    .rw_o        (rw_q),
    .hdr_addr_o  (hdr_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  spi3w_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (hdr_addr),
    .rd_data_o (rd_data),
    .ctrl_o    (ctrl_o)
  );

  spi3w_readback_tx #(
    .DATA_W(DATA_W), .HDR_W(HDR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_s),
    .sclk_fall_i (sclk_fall),
    .cnt_i       (bit_cnt),
    .rw_i        (rw_q),
    .rd_data_i   (rd_data),
    .sdio_o      (spi_sdio_o),
    .oe_o        (spi_sdio_oe_o)
  );
endmodule

// File: rtl/spi3w_ctrl_slave_chk.sv
module spi3w_ctrl_slave_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned HDR_W   = 16,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              oe,
  input logic              rw_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] ctrl
);
  assert_oe_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !oe);

  assert_oe_read_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe |-> (rw_q && bit_cnt >= CNT_W'(HDR_W)));

  assert_ctrl_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(ctrl));

  assert_full_frame_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl) |-> $past(bit_cnt) == CNT_W'(FRAME_W - 1));

  assert_cnt_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> bit_cnt == '0);

  assert_cnt_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W));
endmodule

bind spi3w_ctrl_slave spi3w_ctrl_slave_chk #(
  .DATA_W(DATA_W), .HDR_W(HDR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .oe      (spi_sdio_oe_o),
  .rw_q    (rw_q),
  .bit_cnt (bit_cnt),
  .ctrl    (ctrl_o)
);

// File: tb/spi3w_ctrl_slave_tb.sv
module spi3w_ctrl_slave_tb;
  localparam int H  = 8;  // system clocks per serial half period
  localparam int NV = 9;

  // {frame[23:0], expected ctrl after frame, expected readback}
  localparam logic [39:0] VEC [NV] = '{
    {24'h01003F, 8'h3F, 8'h00},
    {24'h810000, 8'h3F, 8'h3F},
    {24'h0101AA, 8'h3F, 8'h00},
    {24'h0100C5, 8'hC5, 8'h00},
    {24'h800000, 8'hC5, 8'h00},
    {24'h810000, 8'hC5, 8'hC5},
    {24'h01005A, 8'h5A, 8'h00},
    {24'h810000, 8'h5A, 8'h5A},
    {24'hC10000, 8'h5A, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdio = 1'b0;
  logic       sdio_o;
  logic       oe;
  logic [7:0] ctrl;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi3w_ctrl_slave u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .spi_cs_ni     (cs_n),
    .spi_sclk_i    (sclk),
    .spi_sdio_i    (sdio),
    .spi_sdio_o    (sdio_o),
    .spi_sdio_oe_o (oe),
    .ctrl_o        (ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] fr, input int nbits,
                      output logic [7:0] rd, output logic oe_ok);
    rd = '0;
    oe_ok = 1'b1;
    cs_n = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdio = fr[23-i];
      half();
      if (i >= 16 && fr[23]) begin
        rd[23-i] = sdio_o;
        if (!oe) oe_ok = 1'b0;
      end else if (oe) oe_ok = 1'b0;
      sclk = 1'b1;
      half();
    end
    sclk = 1'b0;
    half();
    if (oe) oe_ok = 1'b0;
    cs_n = 1'b1;
    half();
    half();
    if (oe) oe_ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       ok;
    repeat (4) @(negedge clk);
    chk("R1 ctrl at reset", 32'(ctrl), 32'h00);
    chk("R1 oe at reset", 32'(oe), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][39:16], 24, rd, ok);
      if (VEC[v][39]) begin
        chk("R2 ctrl unchanged by read", 32'(ctrl), 32'(VEC[v][15:8]));
        if (VEC[v][38:24] == 15'h100) chk("R5 readback", 32'(rd), 32'(VEC[v][7:0]));
        else                          chk("R6 readback other addr", 32'(rd), 32'(VEC[v][7:0]));
      end else if (VEC[v][38:24] == 15'h100) begin
        chk("R2 write ctrl", 32'(ctrl), 32'(VEC[v][15:8]));
      end else begin
        chk("R3 write other addr", 32'(ctrl), 32'(VEC[v][15:8]));
      end
      chk("R7 oe window", 32'(ok), 32'h1);
    end

    // aborted one bit short
    xfer(24'h01007E, 23, rd, ok);
    chk("R4 aborted write", 32'(ctrl), 32'h5A);
    chk("R7 oe low in aborted write", 32'(ok), 32'h1);

    // short abort, then a clean frame must decode from bit 0
    xfer(24'h0100FF, 10, rd, ok);
    xfer(24'h010081, 24, rd, ok);
    chk("R8 frame after abort", 32'(ctrl), 32'h81);
    xfer(24'h810000, 24, rd, ok);
    chk("R8 readback after abort", 32'(rd), 32'h81);

    // async reset mid operation
    cs_n = 1'b0;
    half();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset ctrl", 32'(ctrl), 32'h00);
    chk("R1 async reset oe", 32'(oe), 32'h0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    half();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule